// File: doc/BRIEF.md
# Embedded Operation Status Flag Generator

This block forms the word a host sees when it reads a flash-style memory while an internal program or erase algorithm is running. A separate controller reports its phase (idle, programming, erase hold window, erasing, suspended, program failed, erase failed) together with bit 7 of the data being written. The block turns that phase into a status word with a data-polling bit, a toggle bit, a timeout bit and an erase-timer bit, and drives an open-drain ready/busy pull-down.

A read access is recognised when output-enable falls while chip-enable is low. Each access captures one word into the read register. While an operation is running, that word is the status word. When the controller is idle or suspended, the word is the array data presented on the data input. The toggle bit changes once per host access rather than once per clock, so a host can poll it. After a failure the toggle keeps running and the pull-down stays on until the controller leaves the failed phase.

Top module: `opstat_flags`

## Requirements
- R1: After reset `rd_data` is all zeros and `rb_pull_low` is 0 (line released).
- R2: A read access (rising edge of `~ce_n & ~oe_n`, seen at a clock edge) in phase code 0 (idle) or code 4 (suspended) loads `rd_data` with `arr_data` as it stands at that clock edge. Outside an access, `rd_data` holds its value.
- R3: A read in code 1 (programming) returns bit 7 equal to the inverse of `tgt_bit7`, and bits 5 and 3 equal to 0.
- R4: A read in code 2 (erase hold window) returns bits 7 and 3 as 0. A read in code 3 (erasing) returns bit 7 as 0 and bit 3 as 1. Bit 5 is 0 in both.
- R5: In codes 1, 2, 3, 5 and 6, each access returns bit 6 equal to the toggle state, which then inverts. Consecutive accesses therefore alternate.
- R6: Accesses in code 4 leave the toggle state unchanged. After a return to code 3, the next access continues the sequence from where it stopped.
- R7: A read in code 5 (program failed) returns bit 7 equal to `tgt_bit7`. A read in code 6 (erase failed) returns bit 7 as 0. Both return bits 5 and 3 as 1, and the toggle keeps alternating.
- R8: In a status word, bits 4, 2, 1, 0 and every bit above 7 read 0.
- R9: `rb_pull_low` is 1 one clock after the phase is 1, 2, 3, 5 or 6, and 0 one clock after it is 0, 4 or 7.
- R10: An access held low for several clocks counts once. An output-enable low with `ce_n` high is not an access and changes neither `rd_data` nor the toggle state.
- R11: Entering code 1 or 2 from code 0 or 7 clears the toggle state, so the first access of a new operation returns bit 6 as 0.
- R12: The unused code 7 behaves as idle: reads return `arr_data` and the line is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_state | input | 3 | Controller phase code (0 idle, 1 program, 2 erase hold, 3 erase, 4 suspended, 5 program failed, 6 erase failed) |
| tgt_bit7 | input | 1 | Bit 7 of the data being programmed |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| arr_data | input | DW | Array read data used when no operation is shown |
| rd_data | output | DW | Word captured at the latest read access |
| rb_pull_low | output | 1 | Open-drain enable: 1 pulls the shared ready/busy line low |

## Verification
The embedded properties check on every cycle several timing relations. The toggle inverts after each access in a running phase and holds otherwise. A new operation clears it. The reserved bits of every status word are zero. The pull-down follows the phase one clock later. The read register holds between accesses. Only the bench scenarios can show the full bit pattern of each phase against the target bit and the array data. They also cover the resumption of the toggle sequence across a suspend, the single count of a long access, and the rejection of reads made with chip-enable high.

// File: rtl/opstat_pkg.sv
package opstat_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_PGM   = 3'd1,
    PH_EHOLD = 3'd2,
    PH_ERASE = 3'd3,
    PH_SUSP  = 3'd4,
    PH_PFAIL = 3'd5,
    PH_EFAIL = 3'd6,
    PH_RSVD  = 3'd7
  } phase_e;

  localparam int POLL_POS = 7;
  localparam int TOG_POS  = 6;
  localparam int TMO_POS  = 5;
  localparam int ETMR_POS = 3;

  // Phases in which an operation is shown: status word, toggling, line low
  function automatic logic op_running(input logic [2:0] s);
    case (phase_e'(s))
      PH_PGM, PH_EHOLD, PH_ERASE, PH_PFAIL, PH_EFAIL: op_running = 1'b1;
      default:                                        op_running = 1'b0;
    endcase
  endfunction

  function automatic logic idle_like(input logic [2:0] s);
    idle_like = (phase_e'(s) == PH_IDLE) || (phase_e'(s) == PH_RSVD);
  endfunction

  // A fresh operation begins when an idle phase gives way to program or hold
  function automatic logic op_begins(input logic [2:0] prev, input logic [2:0] cur);
    op_begins = idle_like(prev) &&
                ((phase_e'(cur) == PH_PGM) || (phase_e'(cur) == PH_EHOLD));
  endfunction

  function automatic logic poll_bit(input logic [2:0] s, input logic tgt);
    case (phase_e'(s))
      PH_PGM:   poll_bit = ~tgt;
      PH_PFAIL: poll_bit = tgt;
      default:  poll_bit = 1'b0;
    endcase
  endfunction

  function automatic logic timeout_bit(input logic [2:0] s);
    timeout_bit = (phase_e'(s) == PH_PFAIL) || (phase_e'(s) == PH_EFAIL);
  endfunction

  function automatic logic erase_timer_bit(input logic [2:0] s);
    erase_timer_bit = (phase_e'(s) == PH_ERASE) || timeout_bit(s);
  endfunction

  function automatic logic [7:0] status_byte(input logic [2:0] s, input logic tgt,
                                             input logic tog);
    logic [7:0] b;
    b           = 8'h00;
    b[POLL_POS] = poll_bit(s, tgt);
    b[TOG_POS]  = tog;
    b[TMO_POS]  = timeout_bit(s);
    b[ETMR_POS] = erase_timer_bit(s);
    status_byte = b;
  endfunction

endpackage

// File: rtl/opstat_strobe.sv
module opstat_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic oe_n,
  output logic access
);
  logic strobe_now;
  logic strobe_q;

  assign strobe_now = ~ce_n & ~oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strobe_q <= 1'b0;
    else        strobe_q <= strobe_now;
  end

  assign access = strobe_now & ~strobe_q;

  // R10: a held strobe yields a single access
  p_one_access_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (access && !ce_n && !oe_n) |=> (!ce_n && !oe_n) |-> !access);

  // R10: chip-enable high never forms an access
  p_ce_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ce_n |-> !access);

endmodule

// File: rtl/opstat_toggle.sv
module opstat_toggle
  import opstat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] phase,
  input  logic       access,
  output logic       tog_view,
  output logic       op_start
);
  logic [2:0] prev_q;
  logic       tog_q;
  logic       flip;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= PH_IDLE;
    else        prev_q <= phase;
  end

  assign op_start = op_begins(prev_q, phase);
  // value presented by an access in this cycle
  assign tog_view = op_start ? 1'b0 : tog_q;
  assign flip     = access & op_running(phase);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    tog_q <= 1'b0;
    else if (flip) tog_q <= ~tog_view;
    else           tog_q <= tog_view;
  end

  // R5: a running access inverts the presented value
  p_tog_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (access && op_running(phase)) |=> (tog_q != $past(tog_view)));

  // R6: accesses in a non-running phase leave the toggle alone
  p_tog_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!op_running(phase) && !op_start) |=> $stable(tog_q));

  // R11: a new operation starts from zero
  p_tog_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (op_start && !access) |=> (tog_q == 1'b0));

endmodule

// File: rtl/opstat_word.sv
module opstat_word
  import opstat_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic [2:0]    phase,
  input  logic          tgt_bit7,
  input  logic          tog,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] word
);
  localparam int PAD = DW - 8;

  logic [DW-1:0] stat_word;

  generate
    if (PAD > 0) begin : g_wide
      assign stat_word = {{PAD{1'b0}}, status_byte(phase, tgt_bit7, tog)};
    end else begin : g_byte
      assign stat_word = status_byte(phase, tgt_bit7, tog);
    end
  endgenerate

  assign word = op_running(phase) ? stat_word : arr_data;

  // R8: reserved positions stay clear in any status word
  always_comb begin
    if (op_running(phase))
      a_rsvd_r8: assert (word[4] == 1'b0 && word[2:0] == 3'b000 && (word >> 8) == '0);
  end

endmodule

// File: rtl/opstat_flags.sv
module opstat_flags
  import opstat_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [2:0]    ctl_state,
  input  logic          tgt_bit7,
  input  logic          ce_n,
  input  logic          oe_n,
  input  logic [DW-1:0] arr_data,
  output logic [DW-1:0] rd_data,
  output logic          rb_pull_low
);
  logic          access;
  logic          tog_view;
  logic          op_start;
  logic [DW-1:0] word;

  opstat_strobe u_strobe (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .oe_n   (oe_n),
    .access (access)
  );

  opstat_toggle u_toggle (
    .clk      (clk),
    .rst_n    (rst_n),
    .phase    (ctl_state),
    .access   (access),
    .tog_view (tog_view),
    .op_start (op_start)
  );

  opstat_word #(.DW(DW)) u_word (
    .phase    (ctl_state),
    .tgt_bit7 (tgt_bit7),
    .tog      (tog_view),
    .arr_data (arr_data),
    .word     (word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_data <= '0;
    else if (access) rd_data <= word;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rb_pull_low <= 1'b0;
    else        rb_pull_low <= op_running(ctl_state);
  end

  // R9: line pulled low one clock after a running phase
  p_line_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
    op_running(ctl_state) |=> rb_pull_low);

  // R9: line released one clock after idle or suspend
  p_line_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !op_running(ctl_state) |=> !rb_pull_low);

  // R2: the read register changes only on an access
  p_rd_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !access |=> $stable(rd_data));

  // R8: captured status words keep reserved bits clear
  p_rsvd_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (access && op_running(ctl_state)) |=> (rd_data[4] == 1'b0 && rd_data[2:0] == 3'b000));

endmodule

// File: tb/sim_opstat_flags.sv
module sim_opstat_flags;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    ctl_state = 3'd0;
  logic          tgt_bit7 = 1'b0;
  logic          ce_n = 1'b1;
  logic          oe_n = 1'b1;
  logic [DW-1:0] arr_data = '0;
  logic [DW-1:0] rd_data;
  logic          rb_pull_low;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  int cur_s = 0;
  bit mtog  = 0;

  always #2.5 clk = ~clk;

  opstat_flags #(.DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .ctl_state(ctl_state), .tgt_bit7(tgt_bit7),
    .ce_n(ce_n), .oe_n(oe_n), .arr_data(arr_data),
    .rd_data(rd_data), .rb_pull_low(rb_pull_low)
  );

  function automatic bit runs(int s);
    return (s == 1) || (s == 2) || (s == 3) || (s == 5) || (s == 6);
  endfunction

  function automatic string tag_of(int s);
    case (s)
      1: return "R3";
      2: return "R4";
      3: return "R4";
      5: return "R7";
      6: return "R7";
      7: return "R12";
      default: return "R2";
    endcase
  endfunction

  function automatic logic [DW-1:0] expect_word(int s, bit t, bit tg, logic [DW-1:0] a);
    int v;
    if (!runs(s)) return a;
    v = tg * 64;
    if (s == 1) v = v + (t ? 0 : 128);
    if (s == 5) v = v + (t ? 128 : 0) + 32 + 8;
    if (s == 6) v = v + 32 + 8;
    if (s == 3) v = v + 8;
    return DW'(v);
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_state(int ns);
    @(negedge clk);
    if ((cur_s == 0 || cur_s == 7) && (ns == 1 || ns == 2)) mtog = 0;
    ctl_state = 3'(ns);
    cur_s = ns;
    @(negedge clk);
    check("R9", DW'(rb_pull_low), DW'(runs(ns)));
  endtask

  task automatic do_read(string req, int hold);
    logic [DW-1:0] e;
    e = expect_word(cur_s, tgt_bit7, mtog, arr_data);
    ce_n = 1'b0; oe_n = 1'b0;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      check(req, rd_data, e);
    end
    if (runs(cur_s)) mtog = ~mtog;
    ce_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    logic [DW-1:0] pats [4];
    logic [DW-1:0] snap;
    pats[0] = 16'hA5C3; pats[1] = 16'h5A3C; pats[2] = 16'hFFFF; pats[3] = 16'h0000;

    repeat (3) @(negedge clk);
    check("R1", rd_data, '0);
    check("R1", DW'(rb_pull_low), '0);
    rst_n = 1'b1;
    @(negedge clk);

    // sweep all phase codes, target bits and array patterns
    for (int s = 0; s < 8; s++) begin
      for (int t = 0; t < 2; t++) begin
        for (int p = 0; p < 4; p++) begin
          set_state(0);
          tgt_bit7 = t[0];
          arr_data = pats[p];
          set_state(s);
          do_read(tag_of(s), 1);
          do_read(runs(s) ? "R5" : tag_of(s), 1);
          do_read(runs(s) ? "R8" : tag_of(s), 1);
        end
      end
    end

    // R11: leave a failure with toggle at 1, then start a new program
    set_state(0);
    set_state(1);
    set_state(5);
    do_read("R7", 1);
    set_state(0);
    set_state(1);
    do_read("R11", 1);
    do_read("R11", 1);

    // R6: suspend freezes the toggle, resume continues it
    set_state(0);
    set_state(2);
    set_state(3);
    do_read("R6", 1);
    set_state(4);
    arr_data = 16'h1234;
    do_read("R6", 1);
    do_read("R6", 1);
    do_read("R6", 1);
    set_state(3);
    do_read("R6", 1);
    do_read("R6", 1);

    // R10: long access counts once, chip-enable high reads are ignored
    do_read("R10", 4);
    snap = rd_data;
    oe_n = 1'b0; ce_n = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R10", rd_data, snap);
    oe_n = 1'b1;
    @(negedge clk);
    do_read("R10", 1);

    // R2: array data taken at the access, later changes not seen
    set_state(0);
    arr_data = 16'hBEEF;
    do_read("R2", 1);
    arr_data = 16'h0F0F;
    @(negedge clk); @(negedge clk);
    check("R2", rd_data, 16'hBEEF);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R5 actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule